// File: doc/BRIEF.md
# Multi-Mode Decimating Down-Converter

This block accepts signed real samples at the full converter rate and hands on a slower stream. A configuration code, sampled only while reset is held, selects one of several modes. In the full-rate pass-through mode the samples are forwarded unchanged. In the halving modes, either the lower or the upper half of the spectrum is kept. In the quartering modes, the signal is first shifted by one of four fixed frequencies, so that the chosen quarter band lands at DC, and then reduced to one quarter of the rate as complex I/Q output.

Every rate reduction is done by a fixed seven-tap half-band filter. The filter runs before any samples are dropped, so it is the anti-alias stage. The quartering path is two of these stages in cascade. Both input and output carry a valid strobe, and the input may pause at any cycle.

Top module: `ddc_multimode`

## Requirements
- R1: The mode is taken from `cfg_mode` only while `rst_n` is low, and changes while running have no effect. The codes are: 0 and 3 pass-through; 1 halve/low band; 2 halve/high band; 4 quarter/centre 0; 5 quarter/centre +Fs/4; 6 quarter/centre Fs/2; 7 quarter/centre -Fs/4.
- R2: In pass-through, each valid input sample appears on `out_i` one cycle later with `out_valid` high, and `out_q` is 0.
- R3: In halve/low, the k-th accepted sample (k from 0) is filtered as y = (-x[n] + 9x[n-2] + 16x[n-3] + 9x[n-4] - x[n-6] + 16) >> 5, using an arithmetic shift and with samples from before reset counted as 0. An output is produced for every odd k, one cycle after that sample is accepted.
- R4: In halve/high, before filtering, accepted samples are multiplied by +1, -1, +1, … starting with +1 on the first sample after reset.
- R5: In the quartering modes, the stage-one outputs feed a second identical stage. One output is produced for every fourth accepted sample, two cycles after it is accepted. Centre 0 multiplies by 1. Centre Fs/2 multiplies by +1/-1 alternately.
- R6: Centre +Fs/4 multiplies by the repeating sequence 1, -j, -1, j. Centre -Fs/4 multiplies by 1, j, -1, -j. The real part feeds I and the imaginary part feeds Q.
- R7: A negation of the most negative value gives the most positive value. Every filter result outside the signed range of `W` bits is clamped to its nearest limit.
- R8: Reset clears `out_valid`, the outputs, the delay lines and the phase counters.
- R9: In every mode other than centre ±Fs/4, `out_q` is 0 whenever `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset; mode capture |
| cfg_mode | input | 3 | Mode code, captured during reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | Signed in-phase (or real) output |
| out_q | output | W | Signed quadrature output |

## Verification
Pass-through and halving results are due one cycle after the accepting edge. Quartering results are due two cycles after the accepting edge of every fourth sample. Outputs are sampled 1 ns after each rising edge. For every cycle of a scenario, the bench builds an expected table of strobe and data from the requirements. It then compares each cycle against that table, so both a late result and an early one are reported. Input gaps shift the accepting edges, and the table follows them.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
// Shared constants of the down-converter: mode codes and half-band taps.
// Assumes a 7-tap half-band whose coefficients sum to 2**HB_SHIFT.
package ddc_pkg;
    localparam logic [2:0] MODE_PASS    = 3'd0;
    localparam logic [2:0] MODE_H_LOW   = 3'd1;
    localparam logic [2:0] MODE_H_HIGH  = 3'd2;
    localparam logic [2:0] MODE_PASS_B  = 3'd3;
    localparam logic [2:0] MODE_Q_DC    = 3'd4;
    localparam logic [2:0] MODE_Q_POS   = 3'd5;
    localparam logic [2:0] MODE_Q_NYQ   = 3'd6;
    localparam logic [2:0] MODE_Q_NEG   = 3'd7;

    localparam int HB_EDGE  = -1;   // taps 0 and 6
    localparam int HB_NEAR  = 9;    // taps 2 and 4
    localparam int HB_MID   = 16;   // tap 3
    localparam int HB_SHIFT = 5;    // normalisation
    localparam int HB_DEPTH = 6;    // stored past samples
endpackage

// File: rtl/ddc_mixer.sv
`timescale 1ns/1ps
// Band-shift stage: multiplies each accepted sample by a mode-dependent
// unit sequence (real or complex) indexed by a 2-bit sample phase.
// Assumes the mode is static between resets; output is combinational.
module ddc_mixer #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          mode,
    input  logic signed [W-1:0] in_data,
    output logic signed [W-1:0] mix_i,
    output logic signed [W-1:0] mix_q
);
    import ddc_pkg::*;

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    logic [1:0]          phase;
    logic signed [W-1:0] neg_x;

    // Sample phase advances once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= '0;
        else if (in_valid) phase <= phase + 2'd1;
    end

    // Saturating negation of the input.
    always_comb neg_x = (in_data == MIN_V) ? MAX_V : -in_data;

    // Select the real and imaginary product for the current phase.
    always_comb begin
        mix_i = in_data;
        mix_q = '0;
        case (mode)
            MODE_H_HIGH, MODE_Q_NYQ: mix_i = phase[0] ? neg_x : in_data;
            MODE_Q_POS, MODE_Q_NEG: begin
                mix_i = phase[0] ? '0 : (phase[1] ? neg_x : in_data);
                if (phase[0])
                    mix_q = (phase[1] ^ (mode == MODE_Q_POS)) ? neg_x : in_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddc_halfband_dec.sv
`timescale 1ns/1ps
// Half-band decimate-by-2 stage: filters every accepted sample and emits
// a rounded, saturated result on every second one (the odd-numbered).
// Assumes the input never exceeds W bits; result is registered.
module ddc_halfband_dec #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    import ddc_pkg::*;

    localparam int AW = W + 6;

    logic signed [W-1:0]  dly [HB_DEPTH];
    logic                 odd;
    logic signed [AW-1:0] acc, rnd, shf;
    logic signed [W-1:0]  sat;
    logic                 ovf;

    // Weighted sum of the window whose newest sample is in_data.
    always_comb begin
        acc = AW'(HB_EDGE) * AW'(in_data)
            + AW'(HB_NEAR) * AW'(dly[1])
            + AW'(HB_MID)  * AW'(dly[2])
            + AW'(HB_NEAR) * AW'(dly[3])
            + AW'(HB_EDGE) * AW'(dly[5]);
        rnd = acc + AW'(1 <<< (HB_SHIFT - 1));
        shf = rnd >>> HB_SHIFT;
        ovf = !(&shf[AW-1:W-1]) && (|shf[AW-1:W-1]);
        sat = ovf ? (shf[AW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                  : shf[W-1:0];
    end

    // Delay line shifts on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HB_DEPTH; k++) dly[k] <= '0;
        end else if (in_valid) begin
            dly[0] <= in_data;
            for (int k = 1; k < HB_DEPTH; k++) dly[k] <= dly[k-1];
        end
    end

    // Decimation phase and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid & odd;
            if (in_valid) odd <= ~odd;
            if (in_valid && odd) out_data <= sat;
        end
    end
endmodule

// File: rtl/ddc_multimode.sv
`timescale 1ns/1ps
// Multi-mode decimating down-converter top: captures the mode in reset,
// shifts the band, and runs one or two half-band stages per channel,
// or forwards samples at full rate in pass-through.
// Assumes cfg_mode is held stable for the last reset cycles.
module ddc_multimode #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_mode,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    import ddc_pkg::*;

    localparam int NCH = 2;

    logic [2:0]          mode_q;
    logic signed [W-1:0] mix [NCH];
    logic                s1_v [NCH];
    logic signed [W-1:0] s1_d [NCH];
    logic                s2_v [NCH];
    logic signed [W-1:0] s2_d [NCH];
    logic                pass_v;
    logic signed [W-1:0] pass_d;

    // Mode capture: only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= cfg_mode;
    end

    ddc_mixer #(.W(W)) u_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode_q),
        .in_data(in_data), .mix_i(mix[0]), .mix_q(mix[1])
    );

    // Two cascaded half-band stages per channel (I, Q).
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ddc_halfband_dec #(.W(W)) u_s1 (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(mix[ch]),
            .out_valid(s1_v[ch]), .out_data(s1_d[ch])
        );
        ddc_halfband_dec #(.W(W)) u_s2 (
            .clk(clk), .rst_n(rst_n), .in_valid(s1_v[ch]), .in_data(s1_d[ch]),
            .out_valid(s2_v[ch]), .out_data(s2_d[ch])
        );
    end

    // Full-rate pass-through register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_v <= 1'b0;
            pass_d <= '0;
        end else begin
            pass_v <= in_valid;
            if (in_valid) pass_d <= in_data;
        end
    end

    // Output selection by captured mode.
    always_comb begin
        case (mode_q)
            MODE_H_LOW, MODE_H_HIGH: begin
                out_valid = s1_v[0]; out_i = s1_d[0]; out_q = '0;
            end
            MODE_Q_DC, MODE_Q_POS, MODE_Q_NYQ, MODE_Q_NEG: begin
                out_valid = s2_v[0]; out_i = s2_d[0]; out_q = s2_d[1];
            end
            default: begin
                out_valid = pass_v; out_i = pass_d; out_q = '0;
            end
        endcase
    end
endmodule

// File: rtl/ddc_multimode_chk.sv
`timescale 1ns/1ps
// Property checker for the down-converter, bound to the top module.
module ddc_multimode_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_data,
    input logic                out_valid,
    input logic signed [W-1:0] out_i,
    input logic signed [W-1:0] out_q,
    input logic [2:0]          mode_q
);
    logic is_pass, is_dec, is_real;
    always_comb begin
        is_pass = (mode_q == 3'd0) || (mode_q == 3'd3);
        is_dec  = !is_pass;
        is_real = (mode_q != 3'd5) && (mode_q != 3'd7);
    end

    // R1: captured mode never moves outside reset
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q));

    // R2: pass-through forwards each sample one cycle later
    a_r2_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pass && in_valid) |=> (out_valid && out_i == $past(in_data)));

    // R3: decimating modes never emit on two adjacent cycles
    a_r3_dec_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dec && out_valid) |=> !out_valid);

    // R9: real modes give a zero quadrature output
    a_r9_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_real && out_valid) |-> (out_q == '0));
endmodule

bind ddc_multimode ddc_multimode_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .mode_q(mode_q)
);

// File: tb/ddc_multimode_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each comparing every cycle
// against a table built from the requirements.
module ddc_multimode_test;
    localparam int W = 16;
    localparam int N = 64;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          cfg_mode = 3'd0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic                out_valid;
    logic signed [W-1:0] out_i, out_q;

    int nchk = 0;
    int nerr = 0;

    int vin [N];
    int xin [N];
    int ev [N];
    int ei [N];
    int eq [N];

    ddc_multimode #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int at(input int a [N], int i);
        return (i < 0) ? 0 : a[i];
    endfunction

    function automatic int hb(input int a [N], int n);
        int s;
        s = -at(a, n) + 9 * at(a, n-2) + 16 * at(a, n-3) + 9 * at(a, n-4) - at(a, n-6);
        return clamp((s + 16) >>> 5);
    endfunction

    function automatic int pattern(int kind, int t);
        case (kind)
            0: return t * 1000 - 20000;
            1: case (t % 8)
                   0: return 3000;   1: return 9000;  2: return -4000;
                   3: return 12000;  4: return -15000; 5: return 7000;
                   6: return -2000;  default: return 500;
               endcase
            2: case (t % 7)
                   0: return -32768; 1: return -32768; 2: return 32767;
                   3: return 32767;  4: return 32767;  5: return 0;
                   default: return -32768;
               endcase
            default: return 10000;
        endcase
    endfunction

    // Expected table per cycle from the requirements.
    task automatic build(int mode);
        int mi [N]; int mq [N]; int mc [N];
        int ai [N]; int aq [N]; int ac [N];
        int nk = 0, na = 0;
        for (int t = 0; t < N; t++) begin
            ev[t] = 0; ei[t] = 0; eq[t] = 0;
            mi[t] = 0; mq[t] = 0; mc[t] = 0; ai[t] = 0; aq[t] = 0; ac[t] = 0;
        end
        for (int t = 0; t < N; t++) begin
            if (vin[t] != 0) begin
                int x = xin[t];
                int ph = nk % 4;
                int sgn = (ph % 2 == 0) ? x : clamp(-x);
                mi[nk] = x; mq[nk] = 0;
                if (mode == 2 || mode == 6) mi[nk] = sgn;
                if (mode == 5 || mode == 7) begin
                    mi[nk] = (ph == 0) ? x : (ph == 2 ? clamp(-x) : 0);
                    if (ph == 1) mq[nk] = (mode == 5) ? clamp(-x) : x;
                    if (ph == 3) mq[nk] = (mode == 5) ? x : clamp(-x);
                end
                mc[nk] = t;
                nk++;
            end
        end
        if (mode == 0 || mode == 3) begin
            for (int k = 0; k < nk; k++) begin
                ev[mc[k]] = 1; ei[mc[k]] = mi[k];
            end
        end else begin
            for (int k = 1; k < nk; k += 2) begin
                ai[na] = hb(mi, k); aq[na] = hb(mq, k); ac[na] = mc[k]; na++;
            end
            if (mode == 1 || mode == 2) begin
                for (int j = 0; j < na; j++) begin
                    ev[ac[j]] = 1; ei[ac[j]] = ai[j];
                end
            end else begin
                for (int j = 1; j < na; j += 2) begin
                    ev[ac[j]+1] = 1; ei[ac[j]+1] = hb(ai, j); eq[ac[j]+1] = hb(aq, j);
                end
            end
        end
    endtask

    // R8: reset drives outputs idle; mode captured here (R1).
    task automatic do_reset(int mode);
        rst_n = 1'b0; cfg_mode = 3'(mode); in_valid = 1'b0; in_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset out_valid", int'(out_valid), 0);
        chk("R8 reset out_i", int'(out_i), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_case(string tag, int mode, int kind, int gaps, int n, int swap);
        do_reset(mode);
        for (int t = 0; t < N; t++) begin
            vin[t] = (t < n && !(gaps != 0 && t % 3 == 2)) ? 1 : 0;
            xin[t] = pattern(kind, t);
        end
        build(mode);
        for (int t = 0; t < n + 4; t++) begin
            in_valid = (vin[t] != 0);
            in_data  = W'(xin[t]);
            if (swap != 0 && t == 2) cfg_mode = 3'd1;
            @(posedge clk);
            #1;
            chk({tag, " valid"}, int'(out_valid), ev[t]);
            if (ev[t] != 0) begin
                chk({tag, " i"}, int'(out_i), ei[t]);
                chk({tag, " q (R9)"}, int'(out_q), eq[t]);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic t_pass;      run_case("R2 pass ramp", 0, 0, 1, 20, 0); endtask
    task automatic t_low;       run_case("R3 low ramp", 1, 0, 0, 24, 0);
                                run_case("R3 low tone gaps", 1, 1, 1, 30, 0); endtask
    task automatic t_high;      run_case("R4 high tone", 2, 1, 0, 24, 0);
                                run_case("R4 high dc", 2, 3, 0, 16, 0); endtask
    task automatic t_quarter;   run_case("R5 centre0 dc", 4, 3, 0, 32, 0);
                                run_case("R5 centre nyq", 6, 1, 1, 40, 0); endtask
    task automatic t_shift;     run_case("R6 centre +fs4", 5, 1, 0, 36, 0);
                                run_case("R6 centre -fs4", 7, 0, 1, 40, 0); endtask
    task automatic t_sat;       run_case("R7 sat low", 1, 2, 0, 28, 0);
                                run_case("R7 sat high", 2, 2, 0, 28, 0);
                                run_case("R7 sat quarter", 5, 2, 0, 32, 0); endtask
    task automatic t_mode_hold; run_case("R1 change ignored", 0, 1, 0, 16, 1);
                                run_case("R1 code3 pass", 3, 0, 0, 10, 0); endtask

    initial begin
        t_pass;
        t_low;
        t_high;
        t_quarter;
        t_shift;
        t_sat;
        t_mode_hold;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule